// File: doc/BRIEF.md
# Dual-Port Four-Register Mailbox

This block is a small shared register shell through which two processor domains, called main and sub, pass commands and flags to each other. It stores four data words: a command word and a flag word travelling from main to sub, and a command word and a flag word travelling from sub to main. Each side owns a complete register port with its own address, write enable, write data and read data. Both ports work in the same cycle, and either side may read or write any of the four words.

Writes replace the stored word. When both sides write the same word in the same clock, main wins and the sub write is dropped. When they write different words in the same clock, both writes land. Every write that lands produces a trace record. The record is placed on a trace channel that belongs to the writing side, and it carries the word index and the data written. Reads are combinational from storage, so a write shows on both read ports from the cycle after its clock edge.

Top module: `mbx_dual_port`

## Requirements
- R1: Four words are addressed by a 2-bit index: 0 = main-to-sub command, 1 = sub-to-main command, 2 = main-to-sub flag, 3 = sub-to-main flag. Each word holds its value independently of the other three.
- R2: For every index, both read ports return the same stored value.
- R3: When both sides write the same index in the same cycle, the main data is stored and the sub data is discarded.
- R4: When the two sides write different indices in the same cycle, both words are updated.
- R5: A write replaces the whole word. A write of zero clears every bit, and no bit keeps an earlier value.
- R6: Read data is combinational from storage. A write committed at a clock edge shows on both read ports after that edge and not before it.
- R7: A synchronous reset (rst_n low at a clock edge) clears all four words to zero. Writes presented during reset are ignored and produce no trace.
- R8: Each committed write raises the valid bit of its own side's trace channel. The channel also carries the index and the data. With the default registered trace, the record appears in the cycle after the commit edge, the same cycle in which the new value becomes readable.
- R9: A sub write that loses a collision produces no sub trace record.
- R10: In a cycle with no write enable, no word changes and no trace valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | 2 | Main-side word index |
| m_we | input | 1 | Main-side write enable |
| m_wdata | input | DATA_W | Main-side write data |
| m_rdata | output | DATA_W | Main-side read data |
| s_addr | input | 2 | Sub-side word index |
| s_we | input | 1 | Sub-side write enable |
| s_wdata | input | DATA_W | Sub-side write data |
| s_rdata | output | DATA_W | Sub-side read data |
| trc_m_vld | output | 1 | Main trace record valid |
| trc_m_idx | output | 2 | Index written by main |
| trc_m_data | output | DATA_W | Data written by main |
| trc_s_vld | output | 1 | Sub trace record valid |
| trc_s_idx | output | 2 | Index written by sub |
| trc_s_data | output | DATA_W | Data written by sub |

## Verification
The bench builds the block with its defaults: DATA_W of 32 and a registered trace (TRACE_REG = 1). At this width, full-word patterns and zero writes reach every bit, which is what the replace behaviour needs. The registered setting puts the trace record in the same cycle as the first readback, so one per-cycle comparison covers storage and trace together. Directed phases cover reset with writes held active, collisions on each index, writes to different indices in the same cycle and idle cycles. These are followed by a long stretch of random traffic in which collisions happen often.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned NUM_WORDS = 4;
   localparam int unsigned IDX_W     = 2;

   typedef enum logic [IDX_W-1:0] {
      MBX_CMD_M2S = 2'd0,
      MBX_CMD_S2M = 2'd1,
      MBX_FLG_M2S = 2'd2,
      MBX_FLG_S2M = 2'd3
   } mbx_idx_e;

   typedef enum logic {
      SIDE_MAIN = 1'b0,
      SIDE_SUB  = 1'b1
   } mbx_side_e;
endpackage

// File: rtl/mbx_wr_arb.sv
module mbx_wr_arb
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                 m_we,
   input  logic [IDX_W-1:0]     m_addr,
   input  logic                 s_we,
   input  logic [IDX_W-1:0]     s_addr,
   output logic [NUM_WORDS-1:0] word_we,
   output logic [NUM_WORDS-1:0] word_sel_m,
   output logic                 commit_m,
   output logic                 commit_s
);
   logic [NUM_WORDS-1:0] hit_m;
   logic [NUM_WORDS-1:0] hit_s;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_comb begin
         hit_m[w]      = m_we && (m_addr == IDX_W'(w));
         hit_s[w]      = s_we && (s_addr == IDX_W'(w));
         word_we[w]    = hit_m[w] | hit_s[w];
         word_sel_m[w] = hit_m[w];
      end
   end

   always_comb begin
      commit_m = |hit_m;
      commit_s = |(hit_s & ~hit_m);
   end

   if (DATA_W == 0) begin : g_bad_w
      $error("mbx_wr_arb: DATA_W must be nonzero");
   end
endmodule

// File: rtl/mbx_reg_bank.sv
module mbx_reg_bank
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WORDS-1:0] word_we,
   input  logic [NUM_WORDS-1:0] word_sel_m,
   input  logic [DATA_W-1:0]    m_wdata,
   input  logic [DATA_W-1:0]    s_wdata,
   input  logic [IDX_W-1:0]     m_addr,
   input  logic [IDX_W-1:0]     s_addr,
   output logic [DATA_W-1:0]    m_rdata,
   output logic [DATA_W-1:0]    s_rdata
);
   logic [DATA_W-1:0] word_q [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_store
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[w] <= '0;
         end else if (word_we[w]) begin
            word_q[w] <= word_sel_m[w] ? m_wdata : s_wdata;
         end
      end

      // R10: a word with no write strobe keeps its value
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !word_we[w] |=> (word_q[w] == $past(word_q[w])));
   end

   always_comb begin
      m_rdata = word_q[m_addr];
      s_rdata = word_q[s_addr];
   end
endmodule

// File: rtl/mbx_trace.sv
module mbx_trace
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          TRACE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_m,
   input  logic              commit_s,
   input  logic [IDX_W-1:0]  m_addr,
   input  logic [IDX_W-1:0]  s_addr,
   input  logic [DATA_W-1:0] m_wdata,
   input  logic [DATA_W-1:0] s_wdata,
   output logic              trc_m_vld,
   output logic [IDX_W-1:0]  trc_m_idx,
   output logic [DATA_W-1:0] trc_m_data,
   output logic              trc_s_vld,
   output logic [IDX_W-1:0]  trc_s_idx,
   output logic [DATA_W-1:0] trc_s_data
);
   if (TRACE_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trc_m_vld  <= 1'b0;
            trc_m_idx  <= '0;
            trc_m_data <= '0;
            trc_s_vld  <= 1'b0;
            trc_s_idx  <= '0;
            trc_s_data <= '0;
         end else begin
            trc_m_vld  <= commit_m;
            trc_m_idx  <= m_addr;
            trc_m_data <= m_wdata;
            trc_s_vld  <= commit_s;
            trc_s_idx  <= s_addr;
            trc_s_data <= s_wdata;
         end
      end
   end else begin : g_comb
      always_comb begin
         trc_m_vld  = rst_n && commit_m;
         trc_m_idx  = m_addr;
         trc_m_data = m_wdata;
         trc_s_vld  = rst_n && commit_s;
         trc_s_idx  = s_addr;
         trc_s_data = s_wdata;
      end
   end

   // R9: the arbiter never lets both sides commit to one index
   a_r9_no_dual_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_m && commit_s) |-> (m_addr != s_addr));
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          TRACE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        m_addr,
   input  logic              m_we,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        s_addr,
   input  logic              s_we,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              trc_m_vld,
   output logic [1:0]        trc_m_idx,
   output logic [DATA_W-1:0] trc_m_data,
   output logic              trc_s_vld,
   output logic [1:0]        trc_s_idx,
   output logic [DATA_W-1:0] trc_s_data
);
   logic [NUM_WORDS-1:0] word_we;
   logic [NUM_WORDS-1:0] word_sel_m;
   logic                 commit_m;
   logic                 commit_s;

   if (IDX_W != 2) begin : g_bad_idx
      $error("mbx_dual_port: index width must be 2");
   end

   mbx_wr_arb #(.DATA_W(DATA_W)) arb_i (
      .m_we       (m_we),
      .m_addr     (m_addr),
      .s_we       (s_we),
      .s_addr     (s_addr),
      .word_we    (word_we),
      .word_sel_m (word_sel_m),
      .commit_m   (commit_m),
      .commit_s   (commit_s)
   );

   mbx_reg_bank #(.DATA_W(DATA_W)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_we    (word_we),
      .word_sel_m (word_sel_m),
      .m_wdata    (m_wdata),
      .s_wdata    (s_wdata),
      .m_addr     (m_addr),
      .s_addr     (s_addr),
      .m_rdata    (m_rdata),
      .s_rdata    (s_rdata)
   );

   mbx_trace #(.DATA_W(DATA_W), .TRACE_REG(TRACE_REG)) trace_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_m   (commit_m),
      .commit_s   (commit_s),
      .m_addr     (m_addr),
      .s_addr     (s_addr),
      .m_wdata    (m_wdata),
      .s_wdata    (s_wdata),
      .trc_m_vld  (trc_m_vld),
      .trc_m_idx  (trc_m_idx),
      .trc_m_data (trc_m_data),
      .trc_s_vld  (trc_s_vld),
      .trc_s_idx  (trc_s_idx),
      .trc_s_data (trc_s_data)
   );

   // R2: equal indices give equal read data
   a_r2_same_view: assert property (@(posedge clk)
      (m_addr == s_addr) |-> (m_rdata == s_rdata));

   // R3: on a collision the main data is stored
   a_r3_main_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && s_we && m_addr == s_addr) |=> (m_addr != $past(m_addr) || m_rdata == $past(m_wdata)));

   // R4: main data lands on its own index when the indices differ
   a_r4_main_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && s_we && m_addr != s_addr) |=> (m_addr != $past(m_addr) || m_rdata == $past(m_wdata)));

   // R4: sub data lands on its own index when the indices differ
   a_r4_sub_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (m_we && s_we && m_addr != s_addr) |=> (s_addr != $past(s_addr) || s_rdata == $past(s_wdata)));

   // R7: reset empties every word
   a_r7_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (m_rdata == '0 && s_rdata == '0));

   if (TRACE_REG) begin : g_trc_chk
      // R8: a main write is traced on the following cycle
      a_r8_main_traced: assert property (@(posedge clk) disable iff (!rst_n)
         m_we |=> (trc_m_vld && trc_m_idx == $past(m_addr) && trc_m_data == $past(m_wdata)));

      // R9: a lost sub write leaves no sub record
      a_r9_loser_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (m_we && s_we && m_addr == s_addr) |=> !trc_s_vld);
   end
endmodule

// File: tb/mbx_dual_port_tb_top.sv
module mbx_dual_port_tb_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    m_addr = '0, s_addr = '0;
   logic          m_we = 1'b0, s_we = 1'b0;
   logic [DW-1:0] m_wdata = '0, s_wdata = '0;
   logic [DW-1:0] m_rdata, s_rdata, trc_m_data, trc_s_data;
   logic          trc_m_vld, trc_s_vld;
   logic [1:0]    trc_m_idx, trc_s_idx;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference state
   logic [DW-1:0] ref_word [4];
   bit            e_m_vld, e_s_vld;
   logic [1:0]    e_m_idx, e_s_idx;
   logic [DW-1:0] e_m_data, e_s_data;

   always #5 clk = ~clk;

   mbx_dual_port #(.DATA_W(DW), .TRACE_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .trc_m_vld(trc_m_vld), .trc_m_idx(trc_m_idx), .trc_m_data(trc_m_data),
      .trc_s_vld(trc_s_vld), .trc_s_idx(trc_s_idx), .trc_s_data(trc_s_data)
   );

   initial begin
      for (int i = 0; i < 4; i++) ref_word[i] = '0;
      e_m_vld = 0; e_s_vld = 0;
      e_m_idx = '0; e_s_idx = '0; e_m_data = '0; e_s_data = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) ref_word[i] = '0;
         e_m_vld = 0;
         e_s_vld = 0;
      end else begin
         e_m_vld  = m_we;
         e_m_idx  = m_addr;
         e_m_data = m_wdata;
         e_s_vld  = s_we && !(m_we && m_addr == s_addr);
         e_s_idx  = s_addr;
         e_s_data = s_wdata;
         if (e_s_vld) ref_word[s_addr] = s_wdata;
         if (m_we) ref_word[m_addr] = m_wdata;
      end
   end

   task automatic cmp(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit rst,
                       input bit mw, input int ma, input logic [DW-1:0] md,
                       input bit sw, input int sa, input logic [DW-1:0] sd);
      @(negedge clk);
      rst_n = rst; m_we = mw; m_addr = 2'(ma); m_wdata = md;
      s_we = sw; s_addr = 2'(sa); s_wdata = sd;
      #1;
      vectors++;
      cmp(tag, "m_rdata", m_rdata, ref_word[m_addr]);
      cmp(tag, "s_rdata", s_rdata, ref_word[s_addr]);
      cmp(tag, "trc_m_vld", DW'(trc_m_vld), DW'(e_m_vld));
      cmp(tag, "trc_s_vld", DW'(trc_s_vld), DW'(e_s_vld));
      if (e_m_vld) begin
         cmp(tag, "trc_m_idx", DW'(trc_m_idx), DW'(e_m_idx));
         cmp(tag, "trc_m_data", trc_m_data, e_m_data);
      end
      if (e_s_vld) begin
         cmp(tag, "trc_s_idx", DW'(trc_s_idx), DW'(e_s_idx));
         cmp(tag, "trc_s_data", trc_s_data, e_s_data);
      end
   endtask

   initial begin
      #1500000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      // R7: reset with writes held active
      step("R7", 0, 1, 0, 32'hDEAD_BEEF, 1, 1, 32'hCAFE_F00D);
      step("R7", 0, 1, 2, 32'h1111_1111, 1, 3, 32'h2222_2222);
      for (int i = 0; i < 4; i++) step("R7", 1, 0, i, '0, 0, 3 - i, '0);
      // R1: one distinct value per index, written by main
      for (int i = 0; i < 4; i++) step("R1", 1, 1, i, 32'hA000_0000 + i, 0, 0, '0);
      // R2: both ports sweep every index
      for (int i = 0; i < 4; i++) step("R2", 1, 0, i, '0, 0, i, '0);
      // R6: read of an index in the cycle of its write shows the old value
      step("R6", 1, 1, 1, 32'h6666_0001, 0, 1, '0);
      step("R6", 1, 0, 1, '0, 0, 1, '0);
      // R8: sub writes every index, traced on its own channel
      for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, '0, 1, i, 32'h5B00_0000 + i);
      // R3 / R9: collisions on each index
      for (int i = 0; i < 4; i++) step("R3", 1, 1, i, 32'h3300_0000 + i, 1, i, 32'h9900_0000 + i);
      step("R9", 1, 0, 0, '0, 0, 3, '0);
      // R4: different indices in the same cycle
      step("R4", 1, 1, 0, 32'h4444_0000, 1, 3, 32'h4444_0003);
      step("R4", 1, 1, 2, 32'h4444_0002, 1, 1, 32'h4444_0001);
      step("R4", 1, 0, 0, '0, 0, 3, '0);
      // R5: full word then zero
      step("R5", 1, 1, 2, 32'hFFFF_FFFF, 0, 2, '0);
      step("R5", 1, 0, 2, '0, 1, 2, 32'h0000_0000);
      step("R5", 1, 0, 2, '0, 0, 2, '0);
      // R10: idle cycles
      for (int i = 0; i < 6; i++) step("R10", 1, 0, i % 4, 32'hFFFF_0000, 0, (i + 1) % 4, 32'h0000_FFFF);
      // R4: mixed random traffic, heavy collisions
      for (int i = 0; i < 3000; i++)
         step("R4", 1, 1'($urandom), int'($urandom % 4), $urandom,
              1'($urandom), int'($urandom % 4), $urandom);
      // R7: reset in mid-traffic clears everything
      step("R7", 0, 1, 1, 32'h7777_7777, 1, 2, 32'h8888_8888);
      for (int i = 0; i < 4; i++) step("R7", 1, 0, i, '0, 0, i, '0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule